// File: doc/BRIEF.md
# Shared Register-File Word Cache

This block keeps two kinds of state in one synchronous RAM. One part is a direct-mapped cache of 36-bit memory words with 512 single-word lines. The other part holds eight banks of sixteen general-purpose registers, so that interrupt code can change bank instead of saving registers. The RAM has one access per cycle, so the two parts take turns. A register access and a cache access never proceed in the same clock.

The CPU side presents one request at a time with a valid/ready handshake. A request is a register read, a register write, a memory read or a memory write. A memory read that hits returns the stored word without touching main memory. A read miss issues a memory-side request, stores the returned word in the indexed line and hands it to the CPU. Memory writes always go through to main memory.

A synchronous invalidate input clears all cache valid bits in a sweep, and reset starts the same sweep. The register banks keep their contents through a sweep. Bank 7 is reserved for microcode, and only requests flagged as microcode may reach it.

Top module: `shared_store_cache`

## Requirements
- R1: A request is accepted at a rising edge where `cpu_req_valid` and `cpu_ready` are both high. A register read returns its data with a one-cycle `cpu_rvalid` pulse, one clock after the accepting edge. `cpu_rvalid` is never high in two consecutive cycles. `cpu_req_kind` codes: 0 register read, 1 register write, 2 memory read, 3 memory write.
- R2: Each bank (`cpu_bank`, 0..7) holds 16 registers (`cpu_regnum`), and all of them are independent. Writing a register number in one bank leaves the same number in every other bank unchanged.
- R3: A register access to bank 7 with `cpu_ucode` low is refused. The write does not change the register, and the read returns zero. With `cpu_ucode` high, bank 7 behaves like any other bank.
- R4: On a memory read miss, the block raises `mem_req_valid` with `mem_req_we` low at the requested address. It returns `mem_resp_data` on `cpu_rvalid` after the response, and `cpu_ready` stays low until then.
- R5: A line hits when its valid bit is set and its stored tag equals address bits [18:9]. The line index is address bits [8:0]. A hit returns data one clock after acceptance and makes no memory request.
- R6: A read miss replaces the indexed line. After that, the address that previously occupied the line misses.
- R7: Every memory write produces one memory-side write with the CPU's address and data, and it produces no `cpu_rvalid`. A write that hits updates the cached word. A write that misses does not allocate a line.
- R8: A high `inv_all` clears every cache valid bit. `cpu_ready` is low in the cycle after `inv_all` is sampled, and it stays low for exactly 513 cycles counted from that edge.
- R9: After synchronous reset, `cpu_ready` stays low for exactly 512 cycles while all lines are invalidated.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, data and direction stay stable. No CPU request is accepted while a memory request is outstanding.
- R11: Invalidation and cache traffic leave the register banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts an invalidate sweep |
| inv_all | input | 1 | Request to invalidate every cache line |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_kind | input | 2 | 0 reg read, 1 reg write, 2 mem read, 3 mem write |
| cpu_ucode | input | 1 | Request comes from microcode (may use bank 7) |
| cpu_bank | input | 3 | Register bank for register requests |
| cpu_regnum | input | 4 | Register number within the bank |
| cpu_addr | input | 19 | Physical word address for memory requests |
| cpu_wdata | input | 36 | Write data |
| cpu_ready | output | 1 | Block can accept a request this cycle |
| cpu_rvalid | output | 1 | Read data valid (one-cycle pulse) |
| cpu_rdata | output | 36 | Read data |
| mem_req_valid | output | 1 | Memory-side request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | 19 | Memory request word address |
| mem_req_wdata | output | 36 | Memory write data |
| mem_resp_valid | input | 1 | Memory read data valid |
| mem_resp_data | input | 36 | Memory read data |

## Verification
The bench keeps a model of line valid bits, tags, registers and memory contents, and predicts hit or miss for every read. Repeated reads of one address separate the hit path from the fill path. Two addresses that share an index and differ in tag separate tag comparison from index-only matching. Writes to a resident line and to an absent line separate write-through update from allocation. The same register number is used across several banks, and bank 7 is accessed with and without the microcode flag, to catch aliasing and a missing guard. The memory responder stalls its ready for several cycles to show that the request is held stable. Invalidation is followed by rereads and register readback, which shows that the sweep clears tags only.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [1:0] {
    K_REG_RD = 2'd0,
    K_REG_WR = 2'd1,
    K_MEM_RD = 2'd2,
    K_MEM_WR = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOOK = 2'd1,
    S_MREQ = 2'd2,
    S_FILL = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/ws_array.sv
// Simple dual-port RAM, registered read: infers block RAM.
module ws_array #(
  parameter int AW = 10,
  parameter int DW = 47
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ws_hit.sv
module ws_hit #(
  parameter int TAG_W = 10
) (
  input  logic             valid,
  input  logic [TAG_W-1:0] stored,
  input  logic [TAG_W-1:0] want,
  output logic             hit
);
  assign hit = valid && (stored == want);
endmodule

// File: rtl/ws_sweeper.sv
// Walks every cache line once, one per clock, after reset or on start.
module ws_sweeper #(
  parameter int LINES = 512,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/shared_store_cache.sv
module shared_store_cache
  import ws_pkg::*;
#(
  parameter int DATA_W    = 36,
  parameter int ADDR_W    = 19,
  parameter int LINES     = 512,
  parameter int BANKS     = 8,
  parameter int REGS      = 16,
  parameter int RSVD_BANK = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inv_all,
  input  logic                         cpu_req_valid,
  input  logic [1:0]                   cpu_req_kind,
  input  logic                         cpu_ucode,
  input  logic [$clog2(BANKS)-1:0]     cpu_bank,
  input  logic [$clog2(REGS)-1:0]      cpu_regnum,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic                         cpu_ready,
  output logic                         cpu_rvalid,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic                         mem_req_we,
  output logic [ADDR_W-1:0]            mem_req_addr,
  output logic [DATA_W-1:0]            mem_req_wdata,
  input  logic                         mem_resp_valid,
  input  logic [DATA_W-1:0]            mem_resp_data
);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int BANK_W  = $clog2(BANKS);
  localparam int REG_W   = $clog2(REGS);
  localparam int RAM_AW  = IDX_W + 1;          // region bit + entry index
  localparam int ENTRY_W = 1 + TAG_W + DATA_W; // valid, tag, data

  // Control state
  ctl_state_e          state;
  logic                inv_pend;
  req_kind_e           q_kind;
  logic [ADDR_W-1:0]   q_addr;
  logic [DATA_W-1:0]   q_wdata;
  logic                q_refuse;

  // Sweeper
  logic                sw_busy;
  logic [IDX_W-1:0]    sw_idx;
  logic                sw_start;

  // Request decode
  logic                accept;
  req_kind_e           in_kind;
  logic                in_is_reg;
  logic                in_refuse;
  logic [RAM_AW-1:0]   in_slot;

  // Array
  logic                ram_we;
  logic [RAM_AW-1:0]   ram_waddr;
  logic [ENTRY_W-1:0]  ram_wdata;
  logic                ram_re;
  logic [ENTRY_W-1:0]  ram_q;

  logic                e_valid;
  logic [TAG_W-1:0]    e_tag;
  logic [DATA_W-1:0]   e_data;
  logic [IDX_W-1:0]    q_idx;
  logic [TAG_W-1:0]    q_tag;
  logic                hit;

  assign cpu_ready = (state == S_IDLE) && !sw_busy && !inv_pend;
  assign accept    = cpu_ready && cpu_req_valid;
  assign in_kind   = req_kind_e'(cpu_req_kind);
  assign in_is_reg = (in_kind == K_REG_RD) || (in_kind == K_REG_WR);
  assign in_refuse = (cpu_bank == BANK_W'(RSVD_BANK)) && !cpu_ucode;
  assign in_slot   = in_is_reg ? {1'b1, IDX_W'({cpu_bank, cpu_regnum})}
                               : {1'b0, cpu_addr[IDX_W-1:0]};

  assign q_idx = q_addr[IDX_W-1:0];
  assign q_tag = q_addr[ADDR_W-1:IDX_W];

  assign e_valid = ram_q[ENTRY_W-1];
  assign e_tag   = ram_q[ENTRY_W-2 -: TAG_W];
  assign e_data  = ram_q[DATA_W-1:0];

  assign sw_start = inv_pend && (state == S_IDLE) && !sw_busy;

  assign mem_req_valid = (state == S_MREQ);
  assign mem_req_we    = (q_kind == K_MEM_WR);
  assign mem_req_addr  = q_addr;
  assign mem_req_wdata = q_wdata;

  ws_array #(.AW(RAM_AW), .DW(ENTRY_W)) u_array (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (in_slot),
    .rdata (ram_q)
  );

  ws_hit #(.TAG_W(TAG_W)) u_hit (
    .valid  (e_valid),
    .stored (e_tag),
    .want   (q_tag),
    .hit    (hit)
  );

  ws_sweeper #(.LINES(LINES), .IDX_W(IDX_W)) u_sweeper (
    .clk   (clk),
    .rst   (rst),
    .start (sw_start),
    .busy  (sw_busy),
    .idx   (sw_idx)
  );

  assign ram_re = accept && (in_kind != K_REG_WR);

  // Single write port: sweep, register write, write-hit update, fill.
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {1'b0, sw_idx};
    ram_wdata = '0;
    if (sw_busy) begin
      ram_we = 1'b1;
    end else if (accept && (in_kind == K_REG_WR) && !in_refuse) begin
      ram_we    = 1'b1;
      ram_waddr = in_slot;
      ram_wdata = {1'b0, {TAG_W{1'b0}}, cpu_wdata};
    end else if ((state == S_LOOK) && (q_kind == K_MEM_WR) && hit) begin
      ram_we    = 1'b1;
      ram_waddr = {1'b0, q_idx};
      ram_wdata = {1'b1, q_tag, q_wdata};
    end else if ((state == S_FILL) && mem_resp_valid) begin
      ram_we    = 1'b1;
      ram_waddr = {1'b0, q_idx};
      ram_wdata = {1'b1, q_tag, mem_resp_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_pend <= 1'b0;
    end else if (inv_all) begin
      inv_pend <= 1'b1;
    end else if (sw_start) begin
      inv_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      q_kind     <= K_REG_RD;
      q_addr     <= '0;
      q_wdata    <= '0;
      q_refuse   <= 1'b0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            q_kind   <= in_kind;
            q_addr   <= cpu_addr;
            q_wdata  <= cpu_wdata;
            q_refuse <= in_refuse;
            if (in_kind != K_REG_WR) state <= S_LOOK;
          end
        end
        S_LOOK: begin
          case (q_kind)
            K_REG_RD: begin
              cpu_rvalid <= 1'b1;
              cpu_rdata  <= q_refuse ? '0 : e_data;
              state      <= S_IDLE;
            end
            K_MEM_RD: begin
              if (hit) begin
                cpu_rvalid <= 1'b1;
                cpu_rdata  <= e_data;
                state      <= S_IDLE;
              end else begin
                state <= S_MREQ;
              end
            end
            K_MEM_WR: state <= S_MREQ;
            default:  state <= S_IDLE;
          endcase
        end
        S_MREQ: begin
          if (mem_req_ready) state <= (q_kind == K_MEM_WR) ? S_IDLE : S_FILL;
        end
        S_FILL: begin
          if (mem_resp_valid) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= mem_resp_data;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ws_checker.sv
module ws_checker #(
  parameter int LINES  = 512,
  parameter int ADDR_W = 19,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              inv_all,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata
);
  localparam int CW = $clog2(LINES) + 1;
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < CW'(LINES)) since_rst <= since_rst + 1'b1;
  end

  a_r10_req_stable: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  a_r10_no_accept_during_mem: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !cpu_ready);

  a_r9_reset_sweep: assert property (@(posedge clk) disable iff (rst)
    since_rst < CW'(LINES) |-> !cpu_ready);

  a_r8_inv_blocks: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> !cpu_ready);

  a_r1_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |=> !cpu_rvalid);
endmodule

bind shared_store_cache ws_checker u_ws_checker (.*);

// File: tb/test_shared_store_cache.sv
module test_shared_store_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_all = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic [1:0]  cpu_req_kind = 2'd0;
  logic        cpu_ucode = 1'b0;
  logic [2:0]  cpu_bank = 3'd0;
  logic [3:0]  cpu_regnum = 4'd0;
  logic [18:0] cpu_addr = '0;
  logic [35:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic        cpu_rvalid;
  logic [35:0] cpu_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [18:0] mem_req_addr;
  logic [35:0] mem_req_wdata;
  logic        mem_resp_valid = 1'b0;
  logic [35:0] mem_resp_data = '0;

  shared_store_cache i_shared_store_cache (.*);

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state
  logic [35:0] bmem [int];
  logic [35:0] rm [128];
  bit          mv [512];
  int          mt [512];
  int          rd_count = 0;
  int          wr_count = 0;
  int          last_rd_addr = -1;
  int          last_wr_addr = -1;
  logic [35:0] last_wr_data = '0;
  int          mem_wait = 0;
  bit          rv_expected = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] bget(input int a);
    logic [18:0] aa;
    aa = a[18:0];
    if (bmem.exists(a)) return bmem[a];
    return {aa, ~aa[16:0]};
  endfunction

  // Memory responder
  initial begin
    int  waitc = 0;
    int  resp_cnt = 0;
    int  resp_addr = 0;
    bit  held = 0;
    logic [18:0] held_addr = '0;
    forever begin
      @(negedge clk);
      mem_resp_valid = 1'b0;
      if (resp_cnt > 0) begin
        resp_cnt--;
        if (resp_cnt == 0) begin
          mem_resp_valid = 1'b1;
          mem_resp_data  = bget(resp_addr);
        end
      end
      if (!rst && mem_req_valid) begin
        if (held) chk(mem_req_addr == held_addr, "R10 request address held",
                      64'(mem_req_addr), 64'(held_addr));
        if (waitc >= mem_wait) begin
          mem_req_ready = 1'b1;
          if (mem_req_we) begin
            bmem[int'(mem_req_addr)] = mem_req_wdata;
            wr_count++;
            last_wr_addr = int'(mem_req_addr);
            last_wr_data = mem_req_wdata;
          end else begin
            rd_count++;
            last_rd_addr = int'(mem_req_addr);
            resp_addr = int'(mem_req_addr);
            resp_cnt = 2;
          end
          waitc = 0;
          held = 0;
        end else begin
          mem_req_ready = 1'b0;
          waitc++;
          held = 1;
          held_addr = mem_req_addr;
        end
      end else begin
        mem_req_ready = 1'b0;
        held = 0;
      end
    end
  end

  // Per-clock comparison of unsolicited outputs
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (cpu_rvalid && !rv_expected)
          chk(0, "R7 no read data unless a read is pending", 1, 0);
        if (mem_req_valid)
          chk(!cpu_ready, "R10 no acceptance during memory request", 64'(cpu_ready), 0);
      end
    end
  end

  task automatic issue(input logic [1:0] k, input int b, input int r,
                       input int a, input logic [35:0] d, input bit uc);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_kind  = k;
    cpu_bank      = 3'(b);
    cpu_regnum    = 4'(r);
    cpu_addr      = 19'(a);
    cpu_wdata     = d;
    cpu_ucode     = uc;
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic wait_rv(output int lat, output logic [35:0] d);
    lat = 0;
    while (!cpu_rvalid && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    d = cpu_rdata;
    @(negedge clk);
    rv_expected = 0;
  endtask

  task automatic reg_wr(input int b, input int r, input logic [35:0] d, input bit uc);
    issue(2'd1, b, r, 0, d, uc);
    if (!(b == 7 && !uc)) rm[b*16 + r] = d;
  endtask

  task automatic reg_rd(input int b, input int r, input bit uc, input string tag);
    int lat;
    logic [35:0] d;
    logic [35:0] exp;
    rv_expected = 1;
    issue(2'd0, b, r, 0, '0, uc);
    wait_rv(lat, d);
    exp = (b == 7 && !uc) ? 36'd0 : rm[b*16 + r];
    chk(d == exp, tag, 64'(d), 64'(exp));
    chk(lat == 1, "R1 register read latency", 64'(lat), 1);
  endtask

  task automatic mem_rd(input int a, input string tag);
    int idx, tg, rc, lat;
    bit hit;
    logic [35:0] d;
    idx = a & 511;
    tg  = a >> 9;
    hit = mv[idx] && (mt[idx] == tg);
    rc  = rd_count;
    rv_expected = 1;
    issue(2'd2, 0, 0, a, '0, 1'b1);
    wait_rv(lat, d);
    chk(d == bget(a), tag, 64'(d), 64'(bget(a)));
    if (hit) begin
      chk(lat == 1, "R5 hit latency", 64'(lat), 1);
      chk(rd_count == rc, "R5 hit makes no memory read", 64'(rd_count), 64'(rc));
    end else begin
      chk(rd_count == rc + 1, "R4 miss makes one memory read", 64'(rd_count), 64'(rc + 1));
      chk(last_rd_addr == a, "R4 miss address", 64'(last_rd_addr), 64'(a));
    end
    mv[idx] = 1;
    mt[idx] = tg;
  endtask

  task automatic mem_wr(input int a, input logic [35:0] d);
    int wc;
    wc = wr_count;
    issue(2'd3, 0, 0, a, d, 1'b1);
    while (!cpu_ready) @(negedge clk);
    chk(wr_count == wc + 1, "R7 one memory write", 64'(wr_count), 64'(wc + 1));
    chk(last_wr_addr == a, "R7 write address", 64'(last_wr_addr), 64'(a));
    chk(last_wr_data == d, "R7 write data", 64'(last_wr_data), 64'(d));
  endtask

  task automatic do_inv();
    int n;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    n = 0;
    while (!cpu_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 513, "R8 invalidate stall length", 64'(n), 513);
    foreach (mv[i]) mv[i] = 0;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    foreach (mv[i]) mv[i] = 0;
    foreach (rm[i]) rm[i] = '0;
    repeat (3) @(negedge clk);
    chk(!cpu_rvalid && !mem_req_valid && !cpu_ready, "R9 reset state",
        {61'd0, cpu_rvalid, mem_req_valid, cpu_ready}, 0);
    rst = 1'b0;
    n = 0;
    while (!cpu_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 512, "R9 reset sweep length", 64'(n), 512);

    // R1, R2: banked registers
    reg_wr(0, 3, 36'h1_2345_6789, 1'b0);
    reg_wr(1, 3, 36'hA_BCDE_F012, 1'b0);
    reg_wr(6, 15, 36'hF_FFFF_FFFF, 1'b0);
    reg_wr(2, 0, 36'h0_0000_0001, 1'b0);
    reg_rd(0, 3, 1'b0, "R2 bank 0 reg 3");
    reg_rd(1, 3, 1'b0, "R2 bank 1 reg 3");
    reg_rd(6, 15, 1'b0, "R1 bank 6 reg 15");
    reg_rd(2, 0, 1'b0, "R1 bank 2 reg 0");

    // R3: reserved bank
    reg_wr(7, 5, 36'h5_5555_5555, 1'b1);
    reg_wr(7, 5, 36'h9_9999_9999, 1'b0);
    reg_rd(7, 5, 1'b1, "R3 refused write left bank 7");
    reg_rd(7, 5, 1'b0, "R3 refused read returns zero");

    // R4, R5: miss then hit
    mem_rd(32'h00123, "R4 miss data");
    mem_rd(32'h00123, "R5 hit data");
    mem_rd(32'h001FF, "R4 miss data top index");
    mem_rd(32'h001FF, "R5 hit data top index");

    // R6, R10: tag conflict with a slow memory
    mem_wait = 3;
    mem_rd(32'h40123, "R6 conflicting tag fills");
    mem_rd(32'h00123, "R6 evicted address misses");
    mem_rd(32'h40123, "R6 evicted again");
    mem_wait = 0;

    // R7: write-through, no allocate on miss
    mem_wr(32'h40123, 36'hC_0FFE_E123);
    mem_rd(32'h40123, "R7 write hit updated line");
    mem_wr(32'h7FFFF, 36'h8_7654_3210);
    mem_rd(32'h7FFFF, "R7 write miss did not allocate");
    mem_wait = 2;
    mem_wr(32'h00005, 36'h3_3333_3333);
    mem_wait = 0;
    mem_rd(32'h00005, "R7 write data visible after fill");

    // R8, R11: invalidate
    mem_rd(32'h00005, "R5 resident before invalidate");
    do_inv();
    mem_rd(32'h00005, "R8 line invalid after sweep");
    mem_rd(32'h7FFFF, "R8 second line invalid after sweep");
    reg_rd(0, 3, 1'b0, "R11 register survives invalidate");
    reg_rd(6, 15, 1'b0, "R11 register survives cache traffic");
    reg_rd(7, 5, 1'b1, "R11 bank 7 survives invalidate");

    // Back-to-back hits on distinct lines
    mem_rd(32'h00005, "R5 hit after refill");
    mem_rd(32'h7FFFF, "R5 hit second line");
    mem_rd(32'h00005, "R5 alternating hits");

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule